// File: doc/BRIEF.md
# Frame-Gated Serial Transmit Lanes

This block drives six serial audio data lanes. All lanes share one bit clock and one frame sync, and both arrive as plain inputs sampled on the system clock. Each lane has a holding register that the host writes and a shift register that sends a 24-bit word MSB first, one bit per rising bit-clock edge. Each lane also has an output enable, which is the lane's tri-state control: when it is low, the pad is in high impedance.

A 24-bit control register sets which lanes are enabled, selects normal or network mode, and can hold the whole transmitter in reset. A lane's enable is acted on only at a frame sync. When an enable is cleared, the lane finishes the word it is shifting before it goes quiet. In normal mode each frame carries one word per lane. In network mode a frame carries a fixed number of 24-bit slots, and each lane reloads from its holding register at every slot boundary. In network mode, if a lane is switched off and back on inside one frame, it stays silent until the next frame starts.

The data-empty flag tells the host when every enabled lane has taken its holding data into its shift register.

Top module: `serial_tx_lanes`

## Requirements
- R1: After reset the control register reads zero, every `sdo_oe` bit is low and `tde` is high.
- R2: The control register keeps bits 22:0 as written and always reads bit 23 as zero. Lane n is enabled by bit n (bits 5:0). Bits 9:8 equal to 01 select network mode. Bit 18 is the transmit reset. The other bits are kept but have no effect.
- R3: A lane starts sending only at a rising bit-clock edge where frame sync is high. A lane enabled between frame syncs keeps `sdo_oe` low until the next frame sync.
- R4: At a frame-sync edge an enabled lane loads its holding register and shows bit 23 on `sdo_data`. Each later rising bit-clock edge shifts out the next lower bit, so 24 edges carry the whole word. In normal mode `sdo_oe` falls at the 25th edge.
- R5: When a lane's enable is cleared part-way through a word, the remaining bits still go out with `sdo_oe` high. The lane then goes to high impedance and does not start at the next frame sync.
- R6: A disabled lane keeps `sdo_oe` low. A host write to its holding register is kept but not sent. Once the lane is enabled, the kept word goes out at the next frame sync.
- R7: `tde` is low while any enabled lane holds host data not yet loaded into its shift register. It falls after a write to an enabled lane's holding register and rises when that data is loaded. Writes to disabled lanes leave it unchanged.
- R8: In network mode a frame carries SLOTS words. At each word boundary inside the frame, every lane that is still enabled reloads from its holding register with no gap. After the last slot, `sdo_oe` falls.
- R9: In network mode, a lane whose enable is cleared and set again inside a frame finishes its current word. It then keeps `sdo_oe` low for the rest of that frame, without consuming its holding data, and resumes at the next frame sync.
- R10: While control bit 18 is set, every lane is idle with `sdo_oe` low.
- R11: Lanes run independently. Several enabled lanes send their own words in the same slots, and lanes that are not enabled stay in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial bit clock; its rising edges are detected in the `clk` domain |
| fsync_in | input | 1 | Frame sync, sampled at each rising bit-clock edge |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 24 | Control register write data |
| ctrl_rdata | output | 24 | Control register readback |
| hold_wr | input | 1 | Holding register write strobe |
| hold_sel | input | 3 | Lane selected by `hold_wr` |
| hold_data | input | 24 | Holding register write data |
| sdo_data | output | 6 | Serial data, one bit per lane |
| sdo_oe | output | 6 | Pad drive enable per lane; low means high impedance |
| tde | output | 1 | Data-empty flag for the enabled lanes |

## Verification
The transmit path is tested with several patterns:
- Two lanes send different words in the same frame, which shows that lanes do not share data.
- An enable written between frame syncs checks that output waits for the next frame and does not start at once.
- A lane is disabled while its holding register already has data. It must send nothing until it is enabled and a frame arrives, and then it must send that exact word.
- An enable is cleared at bit 10 of a word, which separates "finish the word" from "cut off at once".
- A network-mode frame with a fresh holding word before slot 1 confirms back-to-back reloading.
- The same frame is repeated with the enable toggled off and on, which separates "silent until the next frame" from "resume at the next slot".

// File: rtl/serial_tx_lanes.sv
module serial_tx_lanes #(
  parameter int LANES = 6,
  parameter int WORD  = 24,
  parameter int SLOTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_in,
  input  logic                     fsync_in,
  input  logic                     ctrl_wr,
  input  logic [23:0]              ctrl_wdata,
  output logic [23:0]              ctrl_rdata,
  input  logic                     hold_wr,
  input  logic [$clog2(LANES)-1:0] hold_sel,
  input  logic [WORD-1:0]          hold_data,
  output logic [LANES-1:0]         sdo_data,
  output logic [LANES-1:0]         sdo_oe,
  output logic                     tde
);
  localparam int LW = $clog2(LANES);
  localparam int BW = $clog2(WORD);
  localparam int SW = $clog2(SLOTS + 1);
  localparam int MODE_LSB = 8;
  localparam int XRST_BIT = 18;

  logic          sclk_s, sclk_d, fs_s;
  logic [23:0]   ctrl_q;
  logic [BW-1:0] bitpos;
  logic [SW-1:0] slot;
  logic [LANES-1:0] hold_full;

  wire             bit_edge = sclk_s & ~sclk_d;
  wire             fs_edge  = bit_edge & fs_s;
  wire             word_end = bit_edge & ~fs_s & (bitpos == BW'(WORD - 1));
  wire             last_slot = !(slot < SW'(SLOTS - 1));
  wire [LANES-1:0] en   = ctrl_q[LANES-1:0];
  wire             net  = ctrl_q[MODE_LSB+1:MODE_LSB] == 2'b01;
  wire             xrst = ctrl_q[XRST_BIT];

  assign ctrl_rdata = {1'b0, ctrl_q[22:0]};
  assign tde = ~|(en & hold_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      fs_s   <= 1'b0;
      ctrl_q <= '0;
    end else begin
      sclk_s <= sclk_in;
      sclk_d <= sclk_s;
      fs_s   <= fsync_in;
      if (ctrl_wr) ctrl_q <= {1'b0, ctrl_wdata[22:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos <= '0;
      slot   <= '0;
    end else if (xrst || fs_edge) begin
      bitpos <= '0;
      slot   <= '0;
    end else if (bit_edge) begin
      if (bitpos == BW'(WORD - 1)) begin
        bitpos <= '0;
        if (slot != SW'(SLOTS)) slot <= slot + 1'b1;
      end else begin
        bitpos <= bitpos + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic            act_r, drop_r, full_r;
    logic [WORD-1:0] hold_r, sh_r;
    wire reload = word_end & act_r & net & en[g] & ~drop_r & ~last_slot;
    wire load   = ~xrst & ((fs_edge & en[g]) | reload);
    wire wr_me  = hold_wr & (hold_sel == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r  <= 1'b0;
        drop_r <= 1'b0;
        sh_r   <= '0;
      end else if (xrst) begin
        act_r  <= 1'b0;
        drop_r <= 1'b0;
      end else if (fs_edge) begin
        act_r  <= en[g];
        drop_r <= 1'b0;
        if (en[g]) sh_r <= hold_r;
      end else begin
        if (act_r && !en[g]) drop_r <= 1'b1;
        if (word_end && act_r) begin
          if (reload) sh_r <= hold_r;
          else act_r <= 1'b0;
        end else if (bit_edge && act_r) begin
          sh_r <= {sh_r[WORD-2:0], 1'b0};
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_r <= '0;
        full_r <= 1'b0;
      end else if (wr_me) begin
        hold_r <= hold_data;
        full_r <= 1'b1;
      end else if (load) begin
        full_r <= 1'b0;
      end
    end

    assign sdo_oe[g]    = act_r;
    assign sdo_data[g]  = act_r & sh_r[WORD-1];
    assign hold_full[g] = full_r;
  end
endmodule

module serial_tx_lanes_chk #(
  parameter int LANES = 6,
  parameter int WORD  = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bit_edge,
  input logic                     fs_edge,
  input logic [$clog2(WORD)-1:0]  bitpos,
  input logic [23:0]              ctrl_q,
  input logic                     ctrl_wr,
  input logic [23:0]              ctrl_rdata,
  input logic                     hold_wr,
  input logic [$clog2(LANES)-1:0] hold_sel,
  input logic [LANES-1:0]         sdo_data,
  input logic [LANES-1:0]         sdo_oe,
  input logic                     tde
);
  localparam int BW = $clog2(WORD);
  wire             xrst = ctrl_q[18];
  wire [LANES-1:0] en   = ctrl_q[LANES-1:0];

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[23] == 1'b0);

  p_start_on_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sdo_oe & ~$past(sdo_oe))) |-> $past(fs_edge));

  p_stable_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_edge) && !$past(xrst)) |-> ($stable(sdo_data) && $stable(sdo_oe)));

  p_stop_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sdo_oe) & ~sdo_oe)) |->
      ($past(xrst) || ($past(bit_edge) && ($past(fs_edge) || $past(bitpos) == BW'(WORD - 1)))));

  p_fs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_edge && !xrst) |=> ((sdo_oe & ~$past(en)) == '0));

  p_tde_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && !ctrl_wr && (int'(hold_sel) < LANES) && ctrl_q[hold_sel]) |=> !tde);

  p_xrst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xrst |=> (sdo_oe == '0));
endmodule

bind serial_tx_lanes serial_tx_lanes_chk #(.LANES(LANES), .WORD(WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_edge(bit_edge), .fs_edge(fs_edge), .bitpos(bitpos),
  .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .ctrl_rdata(ctrl_rdata), .hold_wr(hold_wr),
  .hold_sel(hold_sel), .sdo_data(sdo_data), .sdo_oe(sdo_oe), .tde(tde)
);

// File: tb/tb_serial_tx_lanes.sv
module tb_serial_tx_lanes;
  localparam int LANES = 6;
  localparam int WORD  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, fsync_in = 1'b0;
  logic ctrl_wr = 1'b0, hold_wr = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic [23:0] ctrl_rdata;
  logic [2:0]  hold_sel = '0;
  logic [WORD-1:0] hold_data = '0;
  logic [LANES-1:0] sdo_data, sdo_oe;
  logic tde;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [LANES-1:0] cap_oe, cap_d, all_oe, any_oe;
  logic [WORD-1:0]  rx [LANES];

  always #2 clk = ~clk;

  serial_tx_lanes dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .fsync_in(fsync_in),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .hold_wr(hold_wr), .hold_sel(hold_sel), .hold_data(hold_data),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .tde(tde)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input bit fs);
    @(negedge clk);
    sclk_in = 1'b1; fsync_in = fs;
    repeat (4) @(negedge clk);
    cap_oe = sdo_oe; cap_d = sdo_data;
    sclk_in = 1'b0; fsync_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [23:0] v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_hold(input int lane, input logic [WORD-1:0] v);
    @(negedge clk);
    hold_wr = 1'b1; hold_sel = 3'(lane); hold_data = v;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  task automatic run_word(input bit fs, input int off_at, input logic [23:0] off_v,
                          input int on_at, input logic [23:0] on_v);
    all_oe = '1; any_oe = '0;
    for (int l = 0; l < LANES; l++) rx[l] = '0;
    for (int i = 0; i < WORD; i++) begin
      if (i == off_at) wr_ctrl(off_v);
      if (i == on_at) wr_ctrl(on_v);
      tick(fs && i == 0);
      all_oe &= cap_oe; any_oe |= cap_oe;
      for (int l = 0; l < LANES; l++) rx[l] = {rx[l][WORD-2:0], cap_d[l]};
    end
  endtask

  task automatic t_reset();
    check(ctrl_rdata == 24'h0, "R1 ctrl after reset", ctrl_rdata, 0);
    check(sdo_oe == '0, "R1 oe after reset", sdo_oe, 0);
    check(tde == 1'b1, "R1 tde after reset", tde, 1);
  endtask

  task automatic t_ctrl_rw();
    wr_ctrl(24'hFFFFFF);
    check(ctrl_rdata == 24'h7FFFFF, "R2 reserved bit reads zero", ctrl_rdata, 24'h7FFFFF);
    wr_ctrl(24'h0);
    check(ctrl_rdata == 24'h0, "R2 ctrl cleared", ctrl_rdata, 0);
  endtask

  task automatic t_mid_enable();
    tick(1'b1); tick(1'b0);
    wr_hold(0, 24'hA5C3F0);
    wr_hold(5, 24'h0F1E2D);
    check(tde == 1'b1, "R7 disabled-lane writes keep tde", tde, 1);
    wr_ctrl(24'h000021);
    check(tde == 1'b0, "R7 tde low with unsent data", tde, 0);
    tick(1'b0); tick(1'b0); tick(1'b0);
    check(cap_oe == '0, "R3 mid-frame enable stays quiet", cap_oe, 0);
    run_word(1'b1, -1, 0, -1, 0);
    check(rx[0] == 24'hA5C3F0, "R4 lane0 word MSB first", rx[0], 24'hA5C3F0);
    check(rx[5] == 24'h0F1E2D, "R11 lane5 own word", rx[5], 24'h0F1E2D);
    check(all_oe[0] && all_oe[5], "R4 oe high for 24 bits", all_oe, 6'h21);
    check((any_oe & 6'h1E) == '0, "R11 other lanes high-Z", any_oe, 6'h21);
    check(tde == 1'b1, "R7 tde high after load", tde, 1);
    tick(1'b0);
    check(cap_oe == '0, "R4 normal mode one word per frame", cap_oe, 0);
  endtask

  task automatic t_disabled_hold();
    wr_ctrl(24'h000001);
    wr_hold(1, 24'h13579B);
    check(tde == 1'b1, "R6 disabled write leaves tde", tde, 1);
    run_word(1'b1, -1, 0, -1, 0);
    check(any_oe[1] == 1'b0, "R6 disabled lane not sent", any_oe, 0);
    wr_ctrl(24'h000002);
    run_word(1'b1, -1, 0, -1, 0);
    check(rx[1] == 24'h13579B && all_oe[1], "R6 kept word sent once enabled", rx[1], 24'h13579B);
  endtask

  task automatic t_disable_mid();
    wr_ctrl(24'h000001);
    wr_hold(0, 24'hC0FFEE);
    run_word(1'b1, 10, 24'h000000, -1, 0);
    check(rx[0] == 24'hC0FFEE, "R5 word completes after disable", rx[0], 24'hC0FFEE);
    check(all_oe[0] == 1'b1, "R5 oe held to word end", all_oe, 1);
    tick(1'b0);
    check(cap_oe[0] == 1'b0, "R5 high-Z after word", cap_oe, 0);
    run_word(1'b1, -1, 0, -1, 0);
    check(any_oe[0] == 1'b0, "R5 no restart at next frame", any_oe, 0);
  endtask

  task automatic t_network();
    wr_ctrl(24'h000104);
    wr_hold(2, 24'h96E1A7);
    run_word(1'b1, -1, 0, -1, 0);
    check(rx[2] == 24'h96E1A7 && all_oe[2], "R8 slot0 word", rx[2], 24'h96E1A7);
    wr_hold(2, 24'h5A0F33);
    check(tde == 1'b0, "R7 tde low in network mode", tde, 0);
    run_word(1'b0, -1, 0, -1, 0);
    check(rx[2] == 24'h5A0F33 && all_oe[2], "R8 slot1 reload", rx[2], 24'h5A0F33);
    check(tde == 1'b1, "R7 tde high after slot reload", tde, 1);
    tick(1'b0);
    check(cap_oe[2] == 1'b0, "R8 high-Z after last slot", cap_oe, 0);
  endtask

  task automatic t_net_reenable();
    wr_hold(2, 24'hE4D2C1);
    run_word(1'b1, 5, 24'h000100, 8, 24'h000104);
    check(rx[2] == 24'hE4D2C1 && all_oe[2], "R9 current word completes", rx[2], 24'hE4D2C1);
    wr_hold(2, 24'h7B3A96);
    run_word(1'b0, -1, 0, -1, 0);
    check(any_oe[2] == 1'b0, "R9 silent rest of frame", any_oe, 0);
    check(tde == 1'b0, "R9 hold data not consumed", tde, 0);
    run_word(1'b1, -1, 0, -1, 0);
    check(rx[2] == 24'h7B3A96 && all_oe[2], "R9 resumes at next frame", rx[2], 24'h7B3A96);
  endtask

  task automatic t_xrst();
    wr_ctrl(24'h000001);
    wr_hold(0, 24'h3C3C3C);
    tick(1'b1); tick(1'b0);
    check(cap_oe[0] == 1'b1, "R10 lane running before reset bit", cap_oe, 1);
    wr_ctrl(24'h040001);
    tick(1'b0);
    check(cap_oe == '0, "R10 reset bit idles lanes", cap_oe, 0);
    tick(1'b1);
    check(cap_oe == '0, "R10 frame ignored under reset bit", cap_oe, 0);
    check(ctrl_rdata == 24'h040001, "R2 reset bit readback", ctrl_rdata, 24'h040001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_mid_enable();
    t_disabled_hold();
    t_disable_mid();
    t_network();
    t_net_reenable();
    t_xrst();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule